// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Bus-Write Invalidation

This block sits between a processor port and a main-memory port. Each address maps to exactly one line: the low bits pick the word inside a block, the next bits pick the line, and the remaining upper bits form the tag. A line holds one block of words, its tag and a valid flag. A read that finds the line valid with an equal tag completes in the same cycle with no memory traffic. A read that misses fetches the whole block over a request/ready memory port, one word per accepted beat, lowest word first. The requested word goes to the processor in the beat that brings it from memory. The rest of the block then arrives in the background.

Every store is written through to memory. A store that hits also updates the cached word. A store that misses leaves the cache untouched. The block also watches writes that other masters make on the shared memory bus. Such a write clears the valid flag of the local line that holds the written block. If that block is being fetched at the time, the fetch still finishes, and the line is then left invalid.

The controller is a four-state machine: `S_IDLE` (lookups, read hits), `S_WRITE` (a store in flight), `S_FILL_STALL` (fill running, processor waiting for its word) and `S_FILL_BG` (fill running, processor released). The transitions are as follows. IDLE goes to WRITE on a store request, and to FILL_STALL on a read miss. WRITE goes back to IDLE when memory accepts the store. FILL_STALL goes to FILL_BG when the requested word arrives. Either fill state goes to IDLE on the last beat of the block. If the requested word is also the last one, FILL_STALL goes straight to IDLE.

Top module: `snoop_wt_cache`

## Requirements
- R1: With the default parameters (10-bit address, 8 lines, 4 words per block), the word-in-block field is address bits [1:0], the line is bits [4:2] and the tag is bits [9:5]; a block can reside only in the line given by its line bits.
- R2: After reset every line is invalid, `cpu_ack`, `cpu_busy` and `mem_req` are low, and the first read of any address misses.
- R3: A read whose line is valid with an equal tag is acknowledged in the cycle of the request with the stored word, and no memory beat takes place.
- R4: A read miss fetches exactly WORDS beats with `mem_we` low, at addresses {tag, line, k} for k = 0, 1, ... in rising order; afterwards that block hits.
- R5: On a read miss, `cpu_ack` is raised in the cycle of the beat that carries the requested word (after exactly `word` earlier beats), and `cpu_rdata` equals that beat's `mem_rdata`.
- R6: `cpu_busy` is high from the cycle after a read-miss request through its acknowledge cycle, and low in every other cycle of a request started from idle.
- R7: After the forwarded word, the fill keeps requesting memory until the block is complete; during it a read hit to another line is acknowledged at once, and a read of the line being filled waits and then hits with no extra beat.
- R8: Every store produces exactly one memory write beat with its address and data; a store that hits also updates the cached word.
- R9: A store that misses allocates nothing: it makes no read beat, and the line keeps its previous block.
- R10: A bus write by another master (`snoop_wr`) whose line and tag match a valid line invalidates it from the next cycle; a bus write with a different tag leaves the line valid.
- R11: A bus write that matches the block under fill, in any cycle of the fill, leaves that line invalid once the fill completes; one with a different tag does not.
- R12: A read miss overwrites the indexed line, so the block that was there misses on its next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held with its fields until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | Request completes this cycle |
| cpu_busy | output | 1 | Read-miss stall: waiting for the requested word |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts or completes the beat this cycle |
| snoop_wr | input | 1 | Another master writes memory this cycle |
| snoop_addr | input | ADDR_W | Word address of that write |

## Verification
The bench first fills every line cold, each time asking for a different word of the block. This separates a correct forwarding beat from an off-by-one in the fill counter or in the field split. A full sweep of hits over all lines and words then tells a correct data index apart from a wrong one. Stores are tried as hits and as misses, which separates write-through with update from write-allocate. Bus writes are tried with a matching and a mismatching tag, both against resident lines and during a fill paced by a memory that is ready only every other cycle. The bench also issues a hit and a read of the line under fill while the background fill is still running.

// File: rtl/snc_pkg.sv
package snc_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WRITE,
        S_FILL_STALL,
        S_FILL_BG
    } snc_state_t;

endpackage

// File: rtl/snc_tag_store.sv
module snc_tag_store #(
    parameter int LINES = 8,
    parameter int TAG_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] lk_line,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     lk_hit,
    input  logic                     sn_en,
    input  logic [$clog2(LINES)-1:0] sn_line,
    input  logic [TAG_W-1:0]         sn_tag,
    input  logic                     fill_start,
    input  logic                     fill_done,
    input  logic [$clog2(LINES)-1:0] fl_line,
    input  logic [TAG_W-1:0]         fl_tag
);
    localparam int LINE_W = $clog2(LINES);

    logic [LINES-1:0] valid_q, valid_d;
    logic [TAG_W-1:0] tag_q [LINES];
    logic             fill_busy_q;
    logic             kill_q;
    logic             sn_fill_match;
    logic             sn_res_match;

    assign sn_fill_match = sn_en && (sn_line == fl_line) && (sn_tag == fl_tag);
    assign sn_res_match  = sn_en && valid_q[sn_line] && (tag_q[sn_line] == sn_tag);
    assign lk_hit        = valid_q[lk_line] && (tag_q[lk_line] == lk_tag);

    always_comb begin
        valid_d = valid_q;
        if (sn_res_match) begin
            valid_d[sn_line] = 1'b0;
        end
        if (fill_start) begin
            valid_d[fl_line] = 1'b0;
        end
        if (fill_done) begin
            valid_d[fl_line] = !(kill_q || sn_fill_match);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q     <= '0;
            fill_busy_q <= 1'b0;
            kill_q      <= 1'b0;
        end else begin
            valid_q <= valid_d;
            if (fill_start) begin
                fill_busy_q <= 1'b1;
                kill_q      <= sn_fill_match;
            end else begin
                if (fill_done) begin
                    fill_busy_q <= 1'b0;
                end
                if (fill_busy_q && sn_fill_match) begin
                    kill_q <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_start) begin
            tag_q[fl_line] <= fl_tag;
        end
    end

    // R10: a matching bus write removes a resident block
    p_snoop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sn_en && valid_q[sn_line] && (tag_q[sn_line] == sn_tag)
        |=> !valid_q[$past(sn_line)]);

    // R7: the line under fill never reports a hit while the fill runs
    p_fill_line_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy_q && !fill_start |-> !valid_q[fl_line]);

    // R11: a bus write seen during the fill leaves the line invalid afterwards
    p_fill_kill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy_q && sn_fill_match |=> !valid_q[$past(fl_line)]);

endmodule

// File: rtl/snc_line_data.sv
module snc_line_data #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_line,
    input  logic [$clog2(WORDS)-1:0] wr_word,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(LINES)-1:0] rd_line,
    input  logic [$clog2(WORDS)-1:0] rd_word,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int IDX_W = $clog2(LINES) + $clog2(WORDS);
    localparam int DEPTH = LINES * WORDS;

    logic [DATA_W-1:0] store_q [DEPTH];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    assign wr_idx  = {wr_line, wr_word};
    assign rd_idx  = {rd_line, rd_word};
    assign rd_data = store_q[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/snc_ctrl.sv
module snc_ctrl
    import snc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int LINES  = 8,
    parameter int WORDS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_ack,
    output logic                     cpu_busy,
    input  logic                     hit,
    input  logic [DATA_W-1:0]        rd_data,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic                     mem_ready,
    output logic                     fill_start,
    output logic                     fill_done,
    output logic [$clog2(LINES)-1:0] fl_line,
    output logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-1:0] fl_tag,
    output logic                     dw_en,
    output logic [$clog2(LINES)-1:0] dw_line,
    output logic [$clog2(WORDS)-1:0] dw_word,
    output logic [DATA_W-1:0]        dw_data
);
    localparam int WORD_W = $clog2(WORDS);
    localparam int LINE_W = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - LINE_W - WORD_W;
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

    snc_state_t        state_q, state_d;
    logic [LINE_W-1:0] fl_line_q;
    logic [TAG_W-1:0]  fl_tag_q;
    logic [WORD_W-1:0] want_q;
    logic [WORD_W-1:0] cnt_q;
    logic              beat;

    logic [WORD_W-1:0] cpu_word;
    logic [LINE_W-1:0] cpu_line;
    logic [TAG_W-1:0]  cpu_tag;

    assign cpu_word = cpu_addr[WORD_W-1:0];
    assign cpu_line = cpu_addr[WORD_W +: LINE_W];
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign beat     = mem_ready && ((state_q == S_FILL_STALL) || (state_q == S_FILL_BG));

    // state register and fill bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            fl_line_q <= '0;
            fl_tag_q  <= '0;
            want_q    <= '0;
            cnt_q     <= '0;
        end else begin
            state_q <= state_d;
            if (fill_start) begin
                fl_line_q <= cpu_line;
                fl_tag_q  <= cpu_tag;
                want_q    <= cpu_word;
                cnt_q     <= '0;
            end else if (beat) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        cpu_ack    = 1'b0;
        cpu_rdata  = rd_data;
        cpu_busy   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {fl_tag_q, fl_line_q, cnt_q};
        mem_wdata  = cpu_wdata;
        fill_start = 1'b0;
        fill_done  = 1'b0;
        fl_line    = fl_line_q;
        fl_tag     = fl_tag_q;
        dw_en      = 1'b0;
        dw_line    = fl_line_q;
        dw_word    = cnt_q;
        dw_data    = mem_rdata;
        unique case (state_q)
            S_IDLE: begin
                fl_line = cpu_line;
                fl_tag  = cpu_tag;
                if (cpu_req) begin
                    if (cpu_we) begin
                        state_d = S_WRITE;
                    end else if (hit) begin
                        cpu_ack = 1'b1;
                    end else begin
                        fill_start = 1'b1;
                        state_d    = S_FILL_STALL;
                    end
                end
            end
            S_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cpu_addr;
                if (mem_ready) begin
                    cpu_ack = 1'b1;
                    state_d = S_IDLE;
                    if (hit) begin
                        dw_en   = 1'b1;
                        dw_line = cpu_line;
                        dw_word = cpu_word;
                        dw_data = cpu_wdata;
                    end
                end
            end
            S_FILL_STALL, S_FILL_BG: begin
                mem_req  = 1'b1;
                cpu_busy = (state_q == S_FILL_STALL);
                if ((state_q == S_FILL_BG) && cpu_req && !cpu_we && hit) begin
                    cpu_ack = 1'b1;
                end
                if (mem_ready) begin
                    dw_en = 1'b1;
                    if ((state_q == S_FILL_STALL) && (cnt_q == want_q)) begin
                        cpu_ack   = 1'b1;
                        cpu_rdata = mem_rdata;
                        state_d   = S_FILL_BG;
                    end
                    if (cnt_q == LAST_WORD) begin
                        fill_done = 1'b1;
                        state_d   = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // R3: an acknowledge always answers a pending request
    p_ack_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_req);

    // R3: a hit from idle makes no memory request
    p_hit_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) && cpu_ack |-> !mem_req);

    // R8: a store completes only together with its memory write beat
    p_store_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack && cpu_we |-> mem_req && mem_we && mem_ready && (mem_wdata == cpu_wdata));

    // R5: the word acknowledged during a stall is the one on the memory bus
    p_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_busy && cpu_ack |-> mem_ready && (cpu_rdata == mem_rdata));

    // R7: a fill read beat that is not the last is followed by another fill request
    p_fill_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ready && !fill_done |=> mem_req && !mem_we);

endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int LINES  = 8,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              snoop_wr,
    input  logic [ADDR_W-1:0] snoop_addr
);
    localparam int WORD_W = $clog2(WORDS);
    localparam int LINE_W = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - LINE_W - WORD_W;

    logic [WORD_W-1:0] cpu_word;
    logic [LINE_W-1:0] cpu_line;
    logic [TAG_W-1:0]  cpu_tag;
    logic [LINE_W-1:0] sn_line;
    logic [TAG_W-1:0]  sn_tag;
    logic              hit;
    logic [DATA_W-1:0] rd_data;
    logic              fill_start;
    logic              fill_done;
    logic [LINE_W-1:0] fl_line;
    logic [TAG_W-1:0]  fl_tag;
    logic              dw_en;
    logic [LINE_W-1:0] dw_line;
    logic [WORD_W-1:0] dw_word;
    logic [DATA_W-1:0] dw_data;

    assign cpu_word = cpu_addr[WORD_W-1:0];
    assign cpu_line = cpu_addr[WORD_W +: LINE_W];
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign sn_line  = snoop_addr[WORD_W +: LINE_W];
    assign sn_tag   = snoop_addr[ADDR_W-1 -: TAG_W];

    snc_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_line    (cpu_line),
        .lk_tag     (cpu_tag),
        .lk_hit     (hit),
        .sn_en      (snoop_wr),
        .sn_line    (sn_line),
        .sn_tag     (sn_tag),
        .fill_start (fill_start),
        .fill_done  (fill_done),
        .fl_line    (fl_line),
        .fl_tag     (fl_tag)
    );

    snc_line_data #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (dw_en),
        .wr_line (dw_line),
        .wr_word (dw_word),
        .wr_data (dw_data),
        .rd_line (cpu_line),
        .rd_word (cpu_word),
        .rd_data (rd_data)
    );

    snc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LINES  (LINES),
        .WORDS  (WORDS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_ack    (cpu_ack),
        .cpu_busy   (cpu_busy),
        .hit        (hit),
        .rd_data    (rd_data),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .fill_start (fill_start),
        .fill_done  (fill_done),
        .fl_line    (fl_line),
        .fl_tag     (fl_tag),
        .dw_en      (dw_en),
        .dw_line    (dw_line),
        .dw_word    (dw_word),
        .dw_data    (dw_data)
    );

endmodule

// File: tb/sim_snoop_wt_cache.sv
module sim_snoop_wt_cache;
    localparam int AW    = 10;
    localparam int DW    = 16;
    localparam int LINES = 8;
    localparam int WORDS = 4;
    localparam int WW    = 2;
    localparam int LW    = 3;
    localparam int TW    = AW - LW - WW;
    localparam int MSIZE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ack;
    logic          cpu_busy;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_ready;
    logic          snoop_wr = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic [DW-1:0] snoop_val = '0;

    logic          slow = 1'b0;
    logic          phase = 1'b0;
    logic [DW-1:0] mem_arr [MSIZE];
    logic [AW-1:0] beat_log [8];
    int            rd_beats = 0;
    int            wr_beats = 0;
    logic [AW-1:0] last_waddr = '0;
    logic [DW-1:0] last_wdata = '0;

    logic          mvalid [LINES];
    logic [TW-1:0] mtag [LINES];

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    snoop_wt_cache u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .cpu_ack    (cpu_ack),
        .cpu_busy   (cpu_busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .snoop_wr   (snoop_wr),
        .snoop_addr (snoop_addr)
    );

    // memory model: ready every cycle, or every other cycle in slow mode
    assign mem_ready = mem_req && (!slow || phase);
    assign mem_rdata = mem_arr[mem_addr];

    always @(posedge clk) begin
        phase <= ~phase;
        if (!rst_n) begin
            for (int i = 0; i < MSIZE; i++) begin
                mem_arr[i] <= DW'(i * 40503 + 7) ^ 16'h5a3c;
            end
        end else begin
            if (snoop_wr) begin
                mem_arr[snoop_addr] <= snoop_val;
            end
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    mem_arr[mem_addr] <= mem_wdata;
                    last_waddr <= mem_addr;
                    last_wdata <= mem_wdata;
                    wr_beats   <= wr_beats + 1;
                end else begin
                    beat_log[rd_beats % 8] <= mem_addr;
                    rd_beats <= rd_beats + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int tg, input int ln, input int wd);
        return {TW'(tg), LW'(ln), WW'(wd)};
    endfunction

    task automatic do_read(input logic [AW-1:0] a, input bit wait_fill);
        int b0;
        int waits;
        bit busy_ok;
        bit exp_hit;
        bit ord_ok;
        logic [LW-1:0] ln;
        logic [TW-1:0] tg;
        logic [WW-1:0] wd;
        ln = a[WW +: LW];
        tg = a[AW-1 -: TW];
        wd = a[WW-1:0];
        exp_hit = mvalid[ln] && (mtag[ln] == tg);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        b0 = rd_beats; waits = 0; busy_ok = 1'b1;
        #2;
        while (1) begin
            if (cpu_busy !== (!exp_hit && waits > 0)) busy_ok = 1'b0;
            if (cpu_ack === 1'b1 || waits > 300) break;
            @(negedge clk); #2; waits++;
        end
        chk(cpu_ack === 1'b1 && cpu_rdata == mem_arr[a], exp_hit ? "R3" : "R5",
            "read data", int'(cpu_rdata), int'(mem_arr[a]));
        chk(busy_ok, "R6", "busy profile", int'(busy_ok), 1);
        if (exp_hit) begin
            chk(waits == 0 && rd_beats == b0, "R3", "hit latency", waits, 0);
        end else begin
            chk(rd_beats - b0 == int'(wd), "R5", "beats before forward", rd_beats - b0, int'(wd));
        end
        @(negedge clk);
        cpu_req = 1'b0;
        if (!exp_hit) begin
            if (wait_fill) begin
                #2;
                while (mem_req) begin @(negedge clk); #2; end
                chk(rd_beats - b0 == WORDS, "R4", "beats per fill", rd_beats - b0, WORDS);
                ord_ok = 1'b1;
                for (int k = 0; k < WORDS; k++) begin
                    if (beat_log[(b0 + k) % 8] != {tg, ln, WW'(k)}) ord_ok = 1'b0;
                end
                chk(ord_ok, "R1", "fill address order", int'(beat_log[b0 % 8]), int'({tg, ln, WW'(0)}));
            end
            mvalid[ln] = 1'b1;
            mtag[ln]   = tg;
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int w0;
        int r0;
        int waits;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        w0 = wr_beats; r0 = rd_beats; waits = 0;
        #2;
        while (cpu_ack !== 1'b1 && waits < 300) begin @(negedge clk); #2; waits++; end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        #2;
        chk(wr_beats - w0 == 1 && last_waddr == a && last_wdata == d, "R8",
            "write-through beat", int'(last_wdata), int'(d));
        chk(rd_beats == r0, "R9", "store makes no read beat", rd_beats - r0, 0);
    endtask

    task automatic do_snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [LW-1:0] ln;
        ln = a[WW +: LW];
        @(negedge clk);
        snoop_wr = 1'b1; snoop_addr = a; snoop_val = d;
        @(negedge clk);
        snoop_wr = 1'b0;
        if (mvalid[ln] && mtag[ln] == a[AW-1 -: TW]) mvalid[ln] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int r0;
        int b0;
        int waits;
        for (int i = 0; i < LINES; i++) begin
            mvalid[i] = 1'b0;
            mtag[i]   = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R2: idle outputs after reset
        chk(cpu_ack === 1'b0 && cpu_busy === 1'b0 && mem_req === 1'b0, "R2",
            "reset outputs", int'({cpu_ack, cpu_busy, mem_req}), 0);

        // cold fill of every line, asking for a different word each time
        for (int l = 0; l < LINES; l++) begin
            r0 = rd_beats;
            do_read(mk(3, l, l % WORDS), 1'b1);
            chk(rd_beats - r0 == WORDS, "R2", "cold read misses", rd_beats - r0, WORDS);
        end

        // hit sweep over every line and word
        for (int l = 0; l < LINES; l++) begin
            for (int w = 0; w < WORDS; w++) begin
                do_read(mk(3, l, w), 1'b1);
            end
        end

        // R12: conflict in line 2
        do_read(mk(12, 2, 1), 1'b1);
        r0 = rd_beats;
        do_read(mk(3, 2, 0), 1'b1);
        chk(rd_beats - r0 == WORDS, "R12", "evicted block refetched", rd_beats - r0, WORDS);

        // R8: store hit updates cache and memory
        do_write(mk(3, 0, 2), 16'hbeef);
        r0 = rd_beats;
        do_read(mk(3, 0, 2), 1'b1);
        chk(cpu_rdata == 16'hbeef && rd_beats == r0, "R8", "store hit updates line",
            int'(cpu_rdata), 16'hbeef);

        // R9: store miss does not allocate
        do_write(mk(9, 1, 0), 16'h1234);
        r0 = rd_beats;
        do_read(mk(3, 1, 0), 1'b1);
        chk(rd_beats == r0, "R9", "old block still resident", rd_beats - r0, 0);
        do_read(mk(9, 1, 0), 1'b1);
        chk(rd_beats - r0 == WORDS, "R9", "store-miss block not cached", rd_beats - r0, WORDS);

        // R10: bus writes with matching and mismatching tag
        do_snoop(mk(3, 4, 1), 16'h7777);
        r0 = rd_beats;
        do_read(mk(3, 4, 1), 1'b1);
        chk(rd_beats - r0 == WORDS && cpu_rdata == 16'h7777, "R10", "matching bus write invalidates",
            rd_beats - r0, WORDS);
        do_snoop(mk(20, 5, 0), 16'h0f0f);
        r0 = rd_beats;
        do_read(mk(3, 5, 0), 1'b1);
        chk(rd_beats == r0, "R10", "other tag keeps line", rd_beats - r0, 0);

        // R7: background fill, hit elsewhere, then read of the filling line
        b0 = rd_beats;
        do_read(mk(7, 6, 0), 1'b0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = mk(3, 7, 2);
        #2;
        chk(cpu_ack === 1'b1 && cpu_rdata == mem_arr[mk(3, 7, 2)] && mem_req === 1'b1, "R7",
            "hit served during fill", int'(cpu_ack), 1);
        @(negedge clk);
        cpu_addr = mk(7, 6, 3); waits = 0;
        #2;
        while (cpu_ack !== 1'b1 && waits < 300) begin @(negedge clk); #2; waits++; end
        chk(waits > 0 && cpu_rdata == mem_arr[mk(7, 6, 3)] && rd_beats - b0 == WORDS, "R7",
            "filling line waits then hits", rd_beats - b0, WORDS);
        @(negedge clk);
        cpu_req = 1'b0;

        // R11: bus write during a slow fill
        slow = 1'b1;
        fork
            do_read(mk(11, 3, 3), 1'b1);
            begin
                repeat (3) @(negedge clk);
                snoop_wr = 1'b1; snoop_addr = mk(11, 3, 2); snoop_val = 16'hcafe;
                @(negedge clk);
                snoop_wr = 1'b0;
            end
        join
        mvalid[3] = 1'b0;
        r0 = rd_beats;
        do_read(mk(11, 3, 2), 1'b1);
        chk(rd_beats - r0 == WORDS && cpu_rdata == 16'hcafe, "R11", "killed fill left invalid",
            rd_beats - r0, WORDS);
        fork
            do_read(mk(13, 0, 1), 1'b1);
            begin
                repeat (3) @(negedge clk);
                snoop_wr = 1'b1; snoop_addr = mk(14, 0, 1); snoop_val = 16'h0042;
                @(negedge clk);
                snoop_wr = 1'b0;
            end
        join
        r0 = rd_beats;
        do_read(mk(13, 0, 1), 1'b1);
        chk(rd_beats == r0, "R11", "other-tag bus write keeps fill", rd_beats - r0, 0);
        slow = 1'b0;

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule